// File: doc/BRIEF.md
# Cascaded Three-Slave Interrupt Controller

This block collects 24 level-sensitive request lines through three 8-input slave units and one 8-input master unit. Slave 0 serves lines 0-7, slave 1 lines 8-15 and slave 2 lines 16-23. Each slave passes its best pending, unmasked input to the master on a cascade line. Slave 0 drives master input 1, slave 1 drives master input 3 and slave 2 drives master input 4. The master raises one CPU interrupt. When the CPU acknowledges it, the block latches a vector that encodes the global line number.

Software reaches the block through a byte-wide I/O port bus. Each unit has a mask register and a command register. The only command that has an effect is a specific end-of-interrupt. To retire line n, software first sends a specific EOI for input n mod 8 to the slave that owns the line. It then sends a second specific EOI for that slave's cascade input to the master.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset, the mask registers at 0x535, 0x537, 0x53B and 0x53D all read 0xFF, no input is in service, cpu_irq is 0 and vector is 0x0000.
- R2: A write to a mask port sets that unit's mask, and a read returns its current value. The slave mask ports are 0x537, 0x53B and 0x53D, and the master mask port is 0x535. Mask bit i set to 1 disables input i. Writing 0x44 to 0x535 enables master inputs 1, 3 and 4.
- R3: Requests are level-sensitive. cpu_irq is 1 exactly while some request can be selected through both its slave and the master, and it falls when that request is removed.
- R4: Inside a unit, a lower input number wins over a higher one. The vector for global line n is 0x800 + 16·n.
- R5: Across slaves, priority follows the master inputs, with input 1 (slave 0) above input 3 (slave 1) above input 4 (slave 2). Setting the master mask bit for a cascade input blocks every line of that slave.
- R6: If cpu_irq is 1 at a clock edge where cpu_ack is 1, the vector of the selected line appears on the next cycle, and the matching slave input and master input are marked in service. cpu_ack with cpu_irq at 0 leaves vector unchanged.
- R7: An input that is in service blocks itself and every higher-numbered input of the same unit. Inputs with lower numbers still pass.
- R8: A command byte 0xE0|k written to a command port clears the in-service bit of input k of that unit. The slave command ports are 0x536, 0x53A and 0x53C, and the master command port is 0x534. A line is served again only after both its slave EOI and its master EOI.
- R9: Command bytes outside the range 0xE0-0xE7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_addr | input | 16 | Byte port address |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, sampled on clock edge |
| io_rdata | output | 8 | Read data for io_addr (mask ports; 0x00 elsewhere) |
| irq_lines | input | 24 | Level request lines, bit n is global line n |
| cpu_ack | input | 1 | Interrupt acknowledge strobe |
| cpu_irq | output | 1 | Interrupt request to CPU |
| vector | output | 16 | Vector latched at the last accepted acknowledge |

## Verification
The bench builds the block with its default parameters: 8-input units, vector base 0x800 and a line shift of 4. These defaults bring every cascade input and the top vector, 0x970 for line 23, within reach. The directed scenarios cover single-unit and cross-unit priority and both kinds of in-service blocking, one in a slave and one at the master. They also check that one EOI alone is not enough and that command bytes just outside the EOI range are rejected.

// File: rtl/cirq_pkg.sv
// Package: shared constants of the cascaded interrupt controller.
// Assumes a fixed three-slave topology; address and cascade tables are sized for it.
package cirq_pkg;
    localparam int UNIT_W    = 8;
    localparam int IDX_W     = $clog2(UNIT_W);
    localparam int N_SLV     = 3;
    localparam int LINES     = N_SLV * UNIT_W;
    localparam int LINE_W    = $clog2(LINES);
    localparam int ADDR_W    = 16;
    localparam int VEC_W     = 16;

    localparam logic [ADDR_W-1:0] SLV_CMD_ADDR  [N_SLV] = '{16'h0536, 16'h053A, 16'h053C};
    localparam logic [ADDR_W-1:0] SLV_MASK_ADDR [N_SLV] = '{16'h0537, 16'h053B, 16'h053D};
    localparam logic [ADDR_W-1:0] MST_CMD_ADDR  = 16'h0534;
    localparam logic [ADDR_W-1:0] MST_MASK_ADDR = 16'h0535;

    localparam int CASC_IN [N_SLV] = '{1, 3, 4};

    localparam logic [4:0] EOI_TAG = 5'b11100;
endpackage

// File: rtl/cirq_port_decode.sv
// Module: byte port decoder. Turns bus writes into per-unit mask/command
// strobes and muxes mask registers onto the read bus.
// Assumes addresses from cirq_pkg; unmapped reads return zero.
module cirq_port_decode
    import cirq_pkg::*;
(
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic [UNIT_W-1:0] slv_mask [N_SLV],
    input  logic [UNIT_W-1:0] mst_mask,
    output logic [N_SLV-1:0]  slv_mask_we,
    output logic [N_SLV-1:0]  slv_cmd_we,
    output logic              mst_mask_we,
    output logic              mst_cmd_we,
    output logic [UNIT_W-1:0] io_rdata
);
    // Write strobe decode per unit.
    always_comb begin
        for (int k = 0; k < N_SLV; k++) begin
            slv_mask_we[k] = io_wr && (io_addr == SLV_MASK_ADDR[k]);
            slv_cmd_we[k]  = io_wr && (io_addr == SLV_CMD_ADDR[k]);
        end
        mst_mask_we = io_wr && (io_addr == MST_MASK_ADDR);
        mst_cmd_we  = io_wr && (io_addr == MST_CMD_ADDR);
    end

    // Read mux of mask registers.
    always_comb begin
        io_rdata = '0;
        for (int k = 0; k < N_SLV; k++)
            if (io_addr == SLV_MASK_ADDR[k]) io_rdata = slv_mask[k];
        if (io_addr == MST_MASK_ADDR) io_rdata = mst_mask;
    end
endmodule

// File: rtl/cirq_unit.sv
// Module: one 8-input priority unit with mask and in-service registers.
// Lowest input index has top priority; an in-service input blocks itself and
// all higher-numbered inputs. Specific EOI (0xE0|k) clears in-service bit k.
module cirq_unit
    import cirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [UNIT_W-1:0] req,
    input  logic              mask_we,
    input  logic              cmd_we,
    input  logic [UNIT_W-1:0] wdata,
    input  logic              ack,
    output logic [UNIT_W-1:0] mask_q,
    output logic              sel_valid,
    output logic [IDX_W-1:0]  sel_idx
);
    logic [UNIT_W-1:0] isr_q;
    logic [UNIT_W-1:0] eoi_clr;
    logic [UNIT_W-1:0] ack_set;
    logic              blocked;

    // Priority search with in-service blocking.
    always_comb begin
        sel_valid = 1'b0;
        sel_idx   = '0;
        blocked   = 1'b0;
        for (int i = 0; i < UNIT_W; i++) begin
            blocked = blocked | isr_q[i];
            if (!sel_valid && !blocked && req[i] && !mask_q[i]) begin
                sel_valid = 1'b1;
                sel_idx   = IDX_W'(i);
            end
        end
    end

    // Decode specific EOI and acknowledge into bit vectors.
    always_comb begin
        eoi_clr = '0;
        ack_set = '0;
        if (cmd_we && wdata[7:3] == EOI_TAG) eoi_clr[wdata[IDX_W-1:0]] = 1'b1;
        if (ack && sel_valid) ack_set[sel_idx] = 1'b1;
    end

    // Mask and in-service state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            isr_q  <= '0;
        end else begin
            if (mask_we) mask_q <= wdata;
            isr_q <= (isr_q & ~eoi_clr) | ack_set;
        end
    end

    // R2 R4
    sel_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> (req[sel_idx] && !mask_q[sel_idx]));
    // R6
    isr_rise_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> ((isr_q & ~$past(isr_q)) == '0));
    // R6
    isr_single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> $onehot0(isr_q & ~$past(isr_q)));
endmodule

// File: rtl/cascade_irq_ctrl.sv
// Module: top of the cascaded interrupt controller. Three slave units feed
// master inputs 1, 3, 4; an accepted acknowledge latches vector
// 0x800 + 16*line and marks both slave and master inputs in service.
module cascade_irq_ctrl
    import cirq_pkg::*;
#(
    parameter logic [VEC_W-1:0] VEC_BASE  = 16'h0800,
    parameter int               VEC_SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       io_addr,
    input  logic [7:0]        io_wdata,
    input  logic              io_wr,
    output logic [7:0]        io_rdata,
    input  logic [23:0]       irq_lines,
    input  logic              cpu_ack,
    output logic              cpu_irq,
    output logic [15:0]       vector
);
    logic [UNIT_W-1:0] slv_mask [N_SLV];
    logic [N_SLV-1:0]  slv_valid;
    logic [IDX_W-1:0]  slv_idx  [N_SLV];
    logic [N_SLV-1:0]  slv_ack;
    logic [N_SLV-1:0]  slv_mask_we, slv_cmd_we;
    logic              mst_mask_we, mst_cmd_we;
    logic [UNIT_W-1:0] mst_mask, mst_req;
    logic              mst_valid;
    logic [IDX_W-1:0]  mst_idx;
    logic [LINE_W-1:0] line_sel;
    logic [VEC_W-1:0]  vec_q;

    cirq_port_decode dec_i (
        .io_addr(io_addr), .io_wr(io_wr), .slv_mask(slv_mask), .mst_mask(mst_mask),
        .slv_mask_we(slv_mask_we), .slv_cmd_we(slv_cmd_we),
        .mst_mask_we(mst_mask_we), .mst_cmd_we(mst_cmd_we), .io_rdata(io_rdata)
    );

    for (genvar k = 0; k < N_SLV; k++) begin : g_slv
        cirq_unit slv_i (
            .clk(clk), .rst_n(rst_n), .req(irq_lines[k*UNIT_W +: UNIT_W]),
            .mask_we(slv_mask_we[k]), .cmd_we(slv_cmd_we[k]), .wdata(io_wdata),
            .ack(slv_ack[k]), .mask_q(slv_mask[k]),
            .sel_valid(slv_valid[k]), .sel_idx(slv_idx[k])
        );
    end

    // Route slave cascade outputs onto master inputs.
    always_comb begin
        mst_req = '0;
        for (int k = 0; k < N_SLV; k++) mst_req[CASC_IN[k]] = slv_valid[k];
    end

    cirq_unit mst_i (
        .clk(clk), .rst_n(rst_n), .req(mst_req),
        .mask_we(mst_mask_we), .cmd_we(mst_cmd_we), .wdata(io_wdata),
        .ack(cpu_ack), .mask_q(mst_mask),
        .sel_valid(mst_valid), .sel_idx(mst_idx)
    );

    // Pick the winning slave, its acknowledge and the global line number.
    always_comb begin
        line_sel = '0;
        for (int k = 0; k < N_SLV; k++) begin
            slv_ack[k] = cpu_ack && mst_valid && (int'(mst_idx) == CASC_IN[k]);
            if (int'(mst_idx) == CASC_IN[k])
                line_sel = LINE_W'(k * UNIT_W) + LINE_W'(slv_idx[k]);
        end
    end

    // Vector latch on accepted acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                     vec_q <= '0;
        else if (cpu_ack && mst_valid)  vec_q <= VEC_BASE + (VEC_W'(line_sel) << VEC_SHIFT);
    end

    assign cpu_irq = mst_valid;
    assign vector  = vec_q;

    // R6
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && !cpu_irq) |=> $stable(vector));
    // R3
    irq_needs_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> (irq_lines != '0));
endmodule

// File: tb/cascade_irq_ctrl_tb_top.sv
// Directed bench for cascade_irq_ctrl: one task per scenario, each checking itself.
module cascade_irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_rdata;
    logic [23:0] irq_lines = '0;
    logic        cpu_ack = 1'b0;
    logic        cpu_irq;
    logic [15:0] vector;
    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    cascade_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
        .io_wr(io_wr), .io_rdata(io_rdata), .irq_lines(irq_lines),
        .cpu_ack(cpu_ack), .cpu_irq(cpu_irq), .vector(vector)
    );

    function automatic logic [15:0] vec_of(int line);
        return 16'h0800 + 16'(line * 16);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; irq_lines = '0; io_wr = 1'b0; cpu_ack = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd_check(string req, logic [15:0] a, logic [7:0] exp);
        @(negedge clk);
        io_addr = a;
        #1;
        check(req, io_rdata, exp);
    endtask

    task automatic ack();
        @(negedge clk);
        cpu_ack = 1'b1;
        @(negedge clk);
        cpu_ack = 1'b0;
    endtask

    task automatic open_all();
        wr(16'h0535, 8'h44);
        wr(16'h0537, 8'h00);
        wr(16'h053B, 8'h00);
        wr(16'h053D, 8'h00);
    endtask

    task automatic settle(logic [23:0] l);
        @(negedge clk);
        irq_lines = l;
        #1;
    endtask

    // R1: reset state.
    task automatic t_reset();
        do_reset();
        rd_check("R1 master mask", 16'h0535, 8'hFF);
        rd_check("R1 slave0 mask", 16'h0537, 8'hFF);
        rd_check("R1 slave1 mask", 16'h053B, 8'hFF);
        rd_check("R1 slave2 mask", 16'h053D, 8'hFF);
        settle(24'hFFFFFF);
        check("R1 irq masked", cpu_irq, 1'b0);
        check("R1 vector", vector, 16'h0000);
    endtask

    // R2: mask write/readback and disabling.
    task automatic t_mask();
        do_reset();
        open_all();
        wr(16'h053B, 8'hA5);
        rd_check("R2 slave1 readback", 16'h053B, 8'hA5);
        settle(24'h000100);
        check("R2 masked line8", cpu_irq, 1'b0);
        settle(24'h000200);
        check("R2 unmasked line9", cpu_irq, 1'b1);
    endtask

    // R3: level sensitivity.
    task automatic t_level();
        do_reset();
        open_all();
        settle(24'h100000);
        check("R3 line20 raise", cpu_irq, 1'b1);
        settle(24'h000000);
        check("R3 line20 drop", cpu_irq, 1'b0);
    endtask

    // R4: priority within a slave and vector encoding.
    task automatic t_prio();
        do_reset();
        open_all();
        settle(24'h000060);
        ack();
        check("R4 line5 over line6", vector, vec_of(5));
        do_reset();
        open_all();
        settle(24'h800000);
        ack();
        check("R4 line23 vector", vector, vec_of(23));
    endtask

    // R5: priority across slaves and cascade masking.
    task automatic t_cascade();
        do_reset();
        open_all();
        settle(24'h010100);
        ack();
        check("R5 slave1 over slave2", vector, vec_of(8));
        do_reset();
        open_all();
        wr(16'h0535, 8'h4C);
        settle(24'h010100);
        ack();
        check("R5 cascade3 masked", vector, vec_of(16));
    endtask

    // R6: acknowledge with no request leaves vector alone.
    task automatic t_ack();
        do_reset();
        open_all();
        settle(24'h000800);
        ack();
        check("R6 vector latched", vector, vec_of(11));
        check("R6 line blocked after ack", cpu_irq, 1'b0);
        ack();
        check("R6 idle ack no change", vector, vec_of(11));
    endtask

    // R7: in-service blocking in slave and in master.
    task automatic t_inservice();
        do_reset();
        open_all();
        settle(24'h000028);
        ack();
        check("R7 line3 vector", vector, vec_of(3));
        wr(16'h0534, 8'hE1);
        #1;
        check("R7 slave isr blocks 3 and 5", cpu_irq, 1'b0);
        settle(24'h00002C);
        check("R7 line2 passes", cpu_irq, 1'b1);
        ack();
        check("R7 line2 vector", vector, vec_of(2));
        do_reset();
        open_all();
        settle(24'h000100);
        ack();
        wr(16'h053A, 8'hE0);
        settle(24'h010100);
        check("R7 master isr blocks slave2", cpu_irq, 1'b0);
        settle(24'h010101);
        check("R7 master input1 passes", cpu_irq, 1'b1);
        ack();
        check("R7 line0 vector", vector, vec_of(0));
    endtask

    // R8 R9: specific EOI on both units; other bytes ignored.
    task automatic t_eoi();
        do_reset();
        open_all();
        settle(24'h001000);
        ack();
        check("R8 line12 vector", vector, vec_of(12));
        wr(16'h053A, 8'h20);
        wr(16'h053A, 8'hE8);
        wr(16'h0534, 8'h63);
        #1;
        check("R9 bad commands ignored", cpu_irq, 1'b0);
        wr(16'h053A, 8'hE4);
        #1;
        check("R8 slave EOI alone", cpu_irq, 1'b0);
        wr(16'h0534, 8'hE3);
        #1;
        check("R8 both EOIs", cpu_irq, 1'b1);
    endtask

    initial begin
        t_reset();
        t_mask();
        t_level();
        t_prio();
        t_cascade();
        t_ack();
        t_inservice();
        t_eoi();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(8 * 100000);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule